// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits on the internal transmit-enable path of a 10 Mb/s twisted-pair transmitter. It passes the enable through to the line driver. If one frame keeps the enable high for longer than a legal frame could last, the block cuts the enable off and raises a jabber flag. It then holds the driver off for as long as the enable stays high. The driver comes back only after the enable has been low without a break for a long recovery interval.

The protection applies only while the 10 Mb/s mode input is high. In any other mode the enable passes through unchanged and all internal state is cleared. Both intervals are parameters counted in clock cycles. The defaults are sized for a 10 MHz clock: about 85 ms to trip and about 500 ms to recover. A testbench can shorten both.

Top module: `jabber_guard`

## Requirements
- R1: In 10 Mb/s mode, with the block not tripped, `txEnOut` equals `txEnIn` in the same cycle.
- R2: When `txEnIn` has been sampled high on TRIP_CYCLES consecutive rising edges in 10 Mb/s mode, the block trips on the last of those edges, and `txEnOut` is low from then on.
- R3: Once tripped, `txEnOut` stays low for every cycle in which `txEnIn` stays high.
- R4: A tripped block releases on the edge that completes RELEASE_CYCLES consecutive low samples of `txEnIn`. From then on, `txEnOut` follows `txEnIn` again.
- R5: While tripped, any high sample of `txEnIn` restarts the recovery count from zero.
- R6: If `txEnIn` goes low before the trip threshold is reached, the trip count returns to zero. A later burst needs TRIP_CYCLES fresh consecutive high samples to trip.
- R7: `jabberFlag` is high exactly from the tripping edge until the releasing edge, and is low at all other times.
- R8: With `mode10` low, `txEnOut` equals `txEnIn` and `jabberFlag` is low. On the next edge both counts clear and any tripped condition ends.
- R9: While `rstN` is low, the block is not tripped, both counts are zero, and `jabberFlag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| mode10 | input | 1 | High selects 10 Mb/s operation, which enables the watchdog |
| txEnIn | input | 1 | Transmit enable from the encoder |
| txEnOut | output | 1 | Gated transmit enable to the line driver |
| jabberFlag | output | 1 | High while the transmitter is held off by the watchdog |

## Verification
`txEnOut` is combinational from `txEnIn` and the registered tripped state, so it is due in the same cycle as the input change. `jabberFlag` and the tripped state change only on the edge that completes a count. A change is therefore first visible in the cycle after the TRIP_CYCLES-th high sample, or after the RELEASE_CYCLES-th low sample. The bench drives the inputs on the falling edge and compares both outputs one time unit later, against counts of consecutive samples that it keeps itself. It then lets the rising edge advance those counts. Every comparison therefore sees a settled value whose due cycle follows directly from the edge count.

// File: rtl/jabber_guard_pkg.sv
package jabber_guard_pkg;

  typedef enum logic {
    GUARD_OPEN = 1'b0,
    GUARD_HELD = 1'b1
  } guardState_e;

  // Strobes sent from the control to the counter datapath
  typedef struct packed {
    logic tripInc;
    logic tripClr;
    logic relInc;
    logic relClr;
  } cntCtl_t;

endpackage

// File: rtl/jabber_counters.sv
module jabber_counters
  import jabber_guard_pkg::*;
#(
  parameter int unsigned TRIP_CYCLES    = 850_000,
  parameter int unsigned RELEASE_CYCLES = 5_000_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  output logic    tripDone,
  output logic    relDone
);

  localparam int unsigned TripW = $clog2(TRIP_CYCLES + 1);
  localparam int unsigned RelW  = $clog2(RELEASE_CYCLES + 1);
  localparam logic [TripW-1:0] TripLast = TripW'(TRIP_CYCLES - 1);
  localparam logic [RelW-1:0]  RelLast  = RelW'(RELEASE_CYCLES - 1);

  logic [TripW-1:0] tripCnt;
  logic [RelW-1:0]  relCnt;

  // Counts consecutive high samples of the transmit enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripCnt <= '0;
    end else if (ctl.tripClr) begin
      tripCnt <= '0;
    end else if (ctl.tripInc) begin
      tripCnt <= tripCnt + 1'b1;
    end
  end

  // Counts consecutive low samples while the transmitter is held off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relCnt <= '0;
    end else if (ctl.relClr) begin
      relCnt <= '0;
    end else if (ctl.relInc) begin
      relCnt <= relCnt + 1'b1;
    end
  end

  assign tripDone = (tripCnt == TripLast);
  assign relDone  = (relCnt == RelLast);

  // The trip count stays below its limit (R2)
  p_trip_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    tripCnt <= TripLast);

  // The release count stays below its limit (R4)
  p_rel_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    relCnt <= RelLast);

  // A clear strobe empties the release count (R5)
  p_rel_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.relClr |=> relCnt == '0);

  // A clear strobe empties the trip count (R6)
  p_trip_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tripClr |=> tripCnt == '0);

endmodule

// File: rtl/jabber_ctrl.sv
module jabber_ctrl
  import jabber_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    mode10,
  input  logic    txEnIn,
  input  logic    tripDone,
  input  logic    relDone,
  output cntCtl_t ctl,
  output logic    txEnOut,
  output logic    jabberFlag
);

  guardState_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    if (!mode10) begin
      stateNext   = GUARD_OPEN;
      ctl.tripClr = 1'b1;
      ctl.relClr  = 1'b1;
    end else begin
      unique case (state)
        GUARD_OPEN: begin
          if (txEnIn) begin
            if (tripDone) begin
              stateNext   = GUARD_HELD;
              ctl.tripClr = 1'b1;
              ctl.relClr  = 1'b1;
            end else begin
              ctl.tripInc = 1'b1;
            end
          end else begin
            ctl.tripClr = 1'b1;
          end
        end
        GUARD_HELD: begin
          if (txEnIn) begin
            ctl.relClr = 1'b1;
          end else if (relDone) begin
            stateNext   = GUARD_OPEN;
            ctl.relClr  = 1'b1;
            ctl.tripClr = 1'b1;
          end else begin
            ctl.relInc = 1'b1;
          end
        end
        default: stateNext = GUARD_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= GUARD_OPEN;
    end else begin
      state <= stateNext;
    end
  end

  logic held;
  assign held       = mode10 && (state == GUARD_HELD);
  assign txEnOut    = txEnIn && !held;
  assign jabberFlag = held;

  // A trip only happens on a cycle in which the enable was sampled high (R2)
  p_trip_needs_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == GUARD_HELD) |-> $past(txEnIn) && $past(mode10));

  // A held transmitter with the enable still high stays held (R3)
  p_hold_while_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == GUARD_HELD && mode10 && txEnIn) |=> state == GUARD_HELD);

  // A release in 10 Mb/s mode follows a low sample of the enable (R4)
  p_release_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(state == GUARD_HELD) && $past(mode10)) |-> !$past(txEnIn));

  // Leaving 10 Mb/s mode ends any held condition (R8)
  p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mode10 |=> state == GUARD_OPEN);

endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jabber_guard_pkg::*;
#(
  parameter int unsigned TRIP_CYCLES    = 850_000,
  parameter int unsigned RELEASE_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic mode10,
  input  logic txEnIn,
  output logic txEnOut,
  output logic jabberFlag
);

  cntCtl_t ctl;
  logic    tripDone;
  logic    relDone;

  jabber_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .mode10     (mode10),
    .txEnIn     (txEnIn),
    .tripDone   (tripDone),
    .relDone    (relDone),
    .ctl        (ctl),
    .txEnOut    (txEnOut),
    .jabberFlag (jabberFlag)
  );

  jabber_counters #(
    .TRIP_CYCLES    (TRIP_CYCLES),
    .RELEASE_CYCLES (RELEASE_CYCLES)
  ) counters_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .tripDone (tripDone),
    .relDone  (relDone)
  );

  // The flag and the gated enable are never both high (R7)
  p_flag_gates_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(jabberFlag && txEnOut));

endmodule

// File: tb/jabber_guard_tb.sv
module jabber_guard_tb_top;

  localparam int unsigned TRIP = 8;
  localparam int unsigned REL  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode10 = 1'b1;
  logic txEnIn = 1'b0;
  logic txEnOut;
  logic jabberFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench-side model: runs of consecutive samples, kept from the requirements
  bit mHeld  = 1'b0;
  int hiRun  = 0;
  int loRun  = 0;

  always #5 clk = ~clk;

  jabber_guard #(
    .TRIP_CYCLES    (TRIP),
    .RELEASE_CYCLES (REL)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .mode10     (mode10),
    .txEnIn     (txEnIn),
    .txEnOut    (txEnOut),
    .jabberFlag (jabberFlag)
  );

  task automatic checkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Drive one cycle on the falling edge, check, then advance the model at the rising edge
  task automatic step(input string req, input logic en, input logic m);
    @(negedge clk);
    txEnIn = en;
    mode10 = m;
    #1;
    checkBit(req, txEnOut, m ? (en & ~mHeld) : en);
    checkBit("R7", jabberFlag, m & mHeld);
    @(posedge clk);
    if (!m) begin
      mHeld = 1'b0; hiRun = 0; loRun = 0;
    end else if (!mHeld) begin
      if (en) begin
        hiRun++;
        if (hiRun == int'(TRIP)) begin mHeld = 1'b1; hiRun = 0; loRun = 0; end
      end else begin
        hiRun = 0;
      end
    end else begin
      if (en) loRun = 0;
      else begin
        loRun++;
        if (loRun == int'(REL)) begin mHeld = 1'b0; loRun = 0; hiRun = 0; end
      end
    end
  endtask

  task automatic burst(input string req, input int hi, input int lo);
    for (int i = 0; i < hi; i++) step(req, 1'b1, 1'b1);
    for (int i = 0; i < lo; i++) step(req, 1'b0, 1'b1);
  endtask

  initial begin
    // R9: reset state
    #2;
    checkBit("R9", jabberFlag, 1'b0);
    checkBit("R9", txEnOut, 1'b0);
    txEnIn = 1'b1;
    #1;
    checkBit("R9", jabberFlag, 1'b0);
    txEnIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1, R6: every burst length below the threshold passes unchanged
    for (int l = 1; l < int'(TRIP); l++) burst("R1", l, 2);
    // R6: a single low sample between two sub-threshold bursts resets the count
    for (int g = 1; g <= 3; g++) burst("R6", TRIP - 1, g);
    burst("R6", 1, 1);

    // R2, R3, R4: bursts from the threshold upward, then full recovery
    for (int l = int'(TRIP); l <= int'(TRIP) + 5; l++) begin
      burst("R2", l, 0);
      step("R3", 1'b1, 1'b1);
      burst("R4", 0, REL + 2);
    end

    // R5: interrupt recovery at every possible point, then recover fully
    burst("R2", TRIP, 0);
    for (int k = 1; k < int'(REL); k++) begin
      burst("R5", 0, k);
      step("R5", 1'b1, 1'b1);
    end
    burst("R4", 0, REL + 1);

    // R8: other mode passes the enable and never trips
    for (int i = 0; i < int'(TRIP) * 3; i++) step("R8", 1'b1, 1'b0);
    step("R8", 1'b0, 1'b0);
    // R8: leaving 10 Mb/s mode while held releases the transmitter
    burst("R2", TRIP + 2, 0);
    step("R8", 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1);
    // R8: leaving the mode clears a partial trip count
    burst("R8", TRIP - 1, 0);
    step("R8", 1'b1, 1'b0);
    burst("R8", TRIP - 1, 1);
    // R8: leaving the mode mid-recovery clears the recovery count
    burst("R2", TRIP, REL - 1);
    step("R8", 1'b0, 1'b0);
    burst("R8", TRIP, REL - 1);
    burst("R4", 0, 3);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule